// File: doc/BRIEF.md
# Word-to-Halfword Memory Access Sequencer

This block connects a 32-bit pipelined core to a memory whose data port is only 16 bits wide. Each core access, whether an instruction fetch or a data load or store, is carried out as two 16-bit memory transfers. The sequencer runs on a clock at twice the core rate, so both transfers finish within one core cycle and the core never waits.

A phase bit, cleared by reset and toggled on every fast edge, marks the first half (upper halfword, even halfword address) and the second half (lower halfword, odd halfword address) of each core cycle. The fast clock is assumed to be phase-aligned with the core clock: a core edge coincides with the fast edge that ends the second half. The core holds its request, write enable, word address and write data steady for the whole core cycle.

On a read, the first halfword is caught in a holding register. At the edge that ends the core cycle, the 32-bit read word is formed as {held upper halfword, second halfword}. On a write, the memory write strobe is raised in both halves, each with the matching halfword of the write data. The memory is assumed to return read data combinationally in the same fast cycle as the address.

Top module: `hwseq_top`

## Requirements
- R1: While rst_n is low at a clock edge, core_rdata resets to 0 and half_sel resets to 0. With no request, mem_en and mem_we are 0.
- R2: After reset, half_sel inverts on every clk edge. 0 marks the first half of a core cycle and 1 marks the second.
- R3: While core_req is 1, mem_addr equals {core_addr, half_sel}. The first half addresses halfword 2×word and the second half addresses 2×word+1.
- R4: While core_req and core_we are both 1, mem_en and mem_we are 1 in both halves. mem_wdata carries core_wdata[31:16] when half_sel=0 and core_wdata[15:0] when half_sel=1.
- R5: While core_req is 1 and core_we is 0, mem_en is 1 and mem_we is 0 in both halves.
- R6: After a read, core_rdata equals {halfword read at 2×word, halfword read at 2×word+1}. It is updated at the clk edge that ends the second half, and it is valid from that edge.
- R7: While core_req is 0, mem_en and mem_we are 0 and core_rdata holds its last value.
- R8: A write access leaves core_rdata unchanged.
- R9: Accesses in consecutive core cycles need no idle cycle. A read in the core cycle that directly follows a write to the same word returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the core rate, phase-aligned with the core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core access request, held for a full core cycle |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 15 | Core word address |
| core_wdata | input | 32 | Core write word |
| core_rdata | output | 32 | Assembled read word |
| half_sel | output | 1 | Current half of the core cycle (0 first, 1 second) |
| mem_addr | output | 16 | Memory halfword address |
| mem_wdata | output | 16 | Memory write halfword |
| mem_rdata | input | 16 | Memory read halfword (combinational return) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |

## Verification
Two functions can fall on the same edge. The edge that completes a write to a word also starts the next access, and that next access may be a read of the same word. The bench issues such writes and reads back-to-back, with no idle cycle between them, and checks on every fast cycle the strobes, the address parity and the halfword order against a word-level reference model. A read must return the new word. The preceding write must leave core_rdata untouched, and the bench confirms this by comparing at both phase edges.

// File: rtl/hwseq_pkg.sv
// Shared types for the halfword access sequencer.
package hwseq_pkg;
    // Which half of the core cycle the fast clock is in.
    typedef enum logic {
        HALF_UPPER = 1'b0,   // first fast cycle: upper halfword, even address
        HALF_LOWER = 1'b1    // second fast cycle: lower halfword, odd address
    } half_e;
endpackage

// File: rtl/hwseq_phase.sv
// Phase generator: tracks which half of the core cycle is active.
// Assumes the fast clock is phase-aligned with the core clock and that
// reset is released at a core-cycle boundary.
module hwseq_phase
    import hwseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output half_e half
);
    // Toggle the half indicator on every fast edge; reset to the first half.
    always_ff @(posedge clk) begin
        if (!rst_n) half <= HALF_UPPER;
        else        half <= (half == HALF_UPPER) ? HALF_LOWER : HALF_UPPER;
    end

    // R2
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (half != $past(half)));
endmodule

// File: rtl/hwseq_lane_mux.sv
// Lane multiplexer: forms the memory address, write halfword and strobes
// for the current half. Assumes CORE_W is exactly two halfwords, and that
// the core holds its request stable across both halves.
module hwseq_lane_mux
    import hwseq_pkg::*;
#(
    parameter int CORE_W = 32,
    parameter int HALF_W = 16,
    parameter int MEM_AW = 16
) (
    input  half_e              half,
    input  logic               req,
    input  logic               we,
    input  logic [MEM_AW-2:0]  word_addr,
    input  logic [CORE_W-1:0]  wdata,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [HALF_W-1:0]  mem_wdata,
    output logic               mem_en,
    output logic               mem_we
);
    localparam int LANES = CORE_W / HALF_W;

    logic [HALF_W-1:0] lane [LANES];
    logic              sel;

    // Slice the core word into halfwords; lane 0 is the most significant.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = wdata[CORE_W-1-i*HALF_W -: HALF_W];
    end

    assign sel = (half == HALF_LOWER);

    // Drive address, data and strobes for the active half.
    always_comb begin
        mem_addr  = {word_addr, sel};
        mem_wdata = lane[sel];
        mem_en    = req;
        mem_we    = req & we;
    end
endmodule

// File: rtl/hwseq_read_asm.sv
// Read assembler: captures the first halfword of a read and, at the end of
// the core cycle, presents {first, second} to the core. Assumes memory read
// data is valid combinationally in the fast cycle that carries the address.
module hwseq_read_asm
    import hwseq_pkg::*;
#(
    parameter int CORE_W = 32,
    parameter int HALF_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  half_e              half,
    input  logic               rd_fire,
    input  logic [HALF_W-1:0]  mem_rdata,
    output logic [CORE_W-1:0]  core_rdata
);
    logic [HALF_W-1:0] upper_q;
    logic              load_upper;
    logic              load_word;

    assign load_upper = rd_fire && (half == HALF_UPPER);
    assign load_word  = rd_fire && (half == HALF_LOWER);

    // Hold the first-half halfword until the second half completes.
    always_ff @(posedge clk) begin
        if (!rst_n)          upper_q <= '0;
        else if (load_upper) upper_q <= mem_rdata;
    end

    // Publish the assembled word at the edge that ends the core cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         core_rdata <= '0;
        else if (load_word) core_rdata <= {upper_q, mem_rdata};
    end

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_word |=> $stable(core_rdata));

    // R6
    rdata_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_word |=> (core_rdata[HALF_W-1:0] == $past(mem_rdata)));
endmodule

// File: rtl/hwseq_top.sv
// Word-to-halfword sequencer top: splits each 32-bit core access into two
// 16-bit memory transfers inside one core cycle. Runs on the doubled clock;
// assumes the core holds its request for two fast cycles starting at a
// core-cycle boundary.
module hwseq_top
    import hwseq_pkg::*;
#(
    parameter int CORE_W = 32,
    parameter int HALF_W = 16,
    parameter int MEM_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_req,
    input  logic               core_we,
    input  logic [MEM_AW-2:0]  core_addr,
    input  logic [CORE_W-1:0]  core_wdata,
    output logic [CORE_W-1:0]  core_rdata,
    output logic               half_sel,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [HALF_W-1:0]  mem_wdata,
    input  logic [HALF_W-1:0]  mem_rdata,
    output logic               mem_en,
    output logic               mem_we
);
    half_e half;
    logic  rd_fire;

    assign half_sel = (half == HALF_LOWER);
    assign rd_fire  = core_req & ~core_we;

    hwseq_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .half  (half)
    );

    hwseq_lane_mux #(.CORE_W(CORE_W), .HALF_W(HALF_W), .MEM_AW(MEM_AW)) u_mux (
        .half      (half),
        .req       (core_req),
        .we        (core_we),
        .word_addr (core_addr),
        .wdata     (core_wdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we)
    );

    hwseq_read_asm #(.CORE_W(CORE_W), .HALF_W(HALF_W)) u_rasm (
        .clk        (clk),
        .rst_n      (rst_n),
        .half       (half),
        .rd_fire    (rd_fire),
        .mem_rdata  (mem_rdata),
        .core_rdata (core_rdata)
    );

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_req |-> (!mem_en && !mem_we));

    // R4
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_we) |-> (mem_en && mem_we));

    // R5
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !core_we) |-> (mem_en && !mem_we));

    // R3
    addr_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (mem_addr[0] == half_sel));

    // R8
    write_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_we) |=> $stable(core_rdata));
endmodule

// File: tb/hwseq_top_bench.sv
`timescale 1ns/1ps
module hwseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        core_req, core_we;
    logic [14:0] core_addr;
    logic [31:0] core_wdata;
    logic [31:0] core_rdata;
    logic        half_sel;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_en, mem_we;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz fast clock

    hwseq_top u_hwseq_top (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .half_sel(half_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we)
    );

    // Bench memory: combinational read, write at the fast edge.
    logic [15:0] mem [0:1023];
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

    function automatic logic [15:0] pat(int i);
        return 16'hA000 ^ 16'(i * 16'h0137);
    endfunction

    // Word-level reference model.
    logic [31:0] ref_w [int];
    logic [31:0] exp_rdata;

    function automatic logic [31:0] ref_read(int wa);
        if (ref_w.exists(wa)) return ref_w[wa];
        return {pat(2*wa), pat(2*wa+1)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_half(bit second, bit req, bit we, logic [14:0] wa, logic [31:0] wd);
        chk("R2 half_sel", 32'(half_sel), 32'(second));
        if (req) begin
            chk("R3 mem_addr", 32'(mem_addr), 32'({wa, second}));
            chk(we ? "R4 mem_en" : "R5 mem_en", 32'(mem_en), 32'd1);
            chk(we ? "R4 mem_we" : "R5 mem_we", 32'(mem_we), 32'(we));
            if (we) chk("R4 mem_wdata", 32'(mem_wdata), 32'(second ? wd[15:0] : wd[31:16]));
        end else begin
            chk("R7 mem_en idle", 32'(mem_en), 32'd0);
            chk("R7 mem_we idle", 32'(mem_we), 32'd0);
        end
        chk(we ? "R8 rdata during write" : "R7 rdata steady mid-cycle", core_rdata, exp_rdata);
    endtask

    // One core cycle: drive at a core boundary, check both halves, then the result.
    task automatic op(bit req, bit we, logic [14:0] wa, logic [31:0] wd);
        core_req = req; core_we = we; core_addr = wa; core_wdata = wd;
        #1 check_half(1'b0, req, we, wa, wd);
        @(negedge clk);
        #1 check_half(1'b1, req, we, wa, wd);
        if (req && we) ref_w[int'(wa)] = wd;
        if (req && !we) exp_rdata = ref_read(int'(wa));
        @(negedge clk);
        if (req && we) begin
            chk("R4 upper at even address", 32'(mem[{wa, 1'b0}]), 32'(wd[31:16]));
            chk("R4 lower at odd address", 32'(mem[{wa, 1'b1}]), 32'(wd[15:0]));
        end
        chk(req ? (we ? "R8 rdata after write" : "R6 rdata") : "R7 rdata hold", core_rdata, exp_rdata);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        rst_n = 1'b0; core_req = 1'b0; core_we = 1'b0; core_addr = '0; core_wdata = '0;
        exp_rdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 rdata reset", core_rdata, 32'd0);
        chk("R1 half_sel reset", 32'(half_sel), 32'd0);
        chk("R1 mem_en reset", 32'(mem_en), 32'd0);
        chk("R1 mem_we reset", 32'(mem_we), 32'd0);
        rst_n = 1'b1;

        op(1, 0, 15'd5, '0);               // R6 read unwritten word
        op(1, 0, 15'd6, '0);               // R9 back-to-back read
        op(0, 0, 15'd5, '0);               // R7 idle holds
        op(0, 1, 15'd9, 32'h1111_2222);    // R7 we without req ignored
        op(1, 1, 15'd5, 32'hDEAD_BEEF);    // R8 write keeps rdata
        op(1, 0, 15'd5, '0);               // R9 read right after write
        op(1, 1, 15'd7, 32'h0123_4567);
        op(0, 0, 15'd0, '0);
        op(1, 0, 15'd7, '0);
        op(1, 1, 15'd511, 32'hFFFF_0000);  // R3 highest bench word
        op(1, 0, 15'd511, '0);
        op(1, 0, 15'd0, '0);
        for (int k = 0; k < 40; k++) begin
            logic [14:0] wa;
            wa = 15'((k * 37) % 64);
            op(1, (k % 3) == 0, wa, 32'h5A00_0000 + 32'(k * 32'h0001_0203));
            if ((k % 5) == 4) op(0, 0, wa, '0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule